// File: doc/BRIEF.md
# Mailbox Command Dispatcher

This block sits between a host-visible mailbox register file and a set of command handlers. When the host sets the doorbell bit, the dispatcher takes the command register apart into a command-set byte, a command byte and an input payload length. It joins the two bytes into a 16-bit opcode and looks that opcode up in a parameterised table of implemented commands. It then either starts the matching handler or completes at once with an error code.

Each table entry gives an opcode, the input length that command expects, and a flag that marks the command as accepting any length. A handler is started over a request/done pair and returns a return code and an output length. On completion the dispatcher writes the command register and the status register together. In the next cycle it clears the doorbell. It stays busy until it sees the doorbell low again, so any doorbell activity during a command has no effect.

Top module: `mbox_dispatch`

## Requirements
- R1: The opcode is the command-set byte (command register bits 15:8) shifted left by 8 and ORed with the command byte (bits 7:0). The input length is held in bits 31:16. On a table hit with an acceptable length, `hnd_req_o` rises with `hnd_idx_o` equal to the table index and `hnd_len_o` equal to the input length. It stays high until `hnd_done_i`.
- R2: An opcode absent from the table completes with return code 0x3 and starts no handler. The length field written back equals the input length.
- R3: A hit whose input length differs from the entry's expected length, on an entry not flagged variable, completes with return code 0x16. It starts no handler, and the length field written back equals the input length.
- R4: An entry flagged variable-length starts its handler for any input length, including 0 and 0xFFFF.
- R5: The completion write of the command register sets bits 15:0 to zero and places the output length in bits 31:16.
- R6: The completion write of the status register places the return code in bits 47:32 and writes every other bit as zero. On a handler completion the code is the handler's own code.
- R7: The doorbell clear pulse comes exactly one cycle after the cycle in which both register writes occur, and never in the same cycle.
- R8: Each doorbell produces exactly one completion write and at most one handler start. A doorbell or command-register write by the host while a command is in progress is ignored.
- R9: A handler output length above `PAYLOAD_MAX` completes with return code 0x4 and a length field of 0. A length equal to `PAYLOAD_MAX` is accepted.
- R10: Out of reset, no handler request, register write or doorbell clear is active.
- R11: The handler index and input length come from the command register as it stood when the doorbell was accepted. Later host writes do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| db_i | input | 1 | Doorbell bit from the control register |
| cmd_reg_i | input | 16+LEN_W | Current command register contents |
| cmd_wr_o | output | 1 | Write strobe for the command register |
| cmd_wdata_o | output | 16+LEN_W | Command register write data |
| sts_wr_o | output | 1 | Write strobe for the status register |
| sts_wdata_o | output | STS_W | Status register write data |
| db_clr_o | output | 1 | Clears the doorbell bit |
| hnd_req_o | output | 1 | Handler request, held until done |
| hnd_idx_o | output | IDX_W | Table index of the started command |
| hnd_len_o | output | LEN_W | Input payload length given to the handler |
| hnd_done_i | input | 1 | Handler finished |
| hnd_rc_i | input | 16 | Handler return code |
| hnd_olen_i | input | LEN_W | Handler output length |

## Verification
Two functions can meet in a single cycle. One is the start of a handler. The other is its completion together with the output-length range check. The bench provokes this with a handler that raises done in the same cycle its request first appears. It then judges the written-back code and length against a value computed independently, including lengths on both sides of `PAYLOAD_MAX`. A second overlap comes from a host write that re-rings the doorbell and rewrites the command register while a slow handler is running. For that case the bench confirms a single handler start with the original index and length, and confirms that the completion write still replaces the scribbled register.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [15:0] RC_UNSUPPORTED = 16'h0003;
  localparam logic [15:0] RC_INTERNAL    = 16'h0004;
  localparam logic [15:0] RC_BAD_LENGTH  = 16'h0016;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_WRITE = 3'd2,
    ST_CLEAR = 3'd3,
    ST_DRAIN = 3'd4
  } seq_state_e;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mbox_lookup.sv
module mbox_lookup #(
  parameter int LEN_W = 16,
  parameter int N_CMD = 13,
  parameter logic [N_CMD*16-1:0]    TBL_OPC = '0,
  parameter logic [N_CMD*LEN_W-1:0] TBL_LEN = '0,
  parameter logic [N_CMD-1:0]       TBL_VAR = '0,
  localparam int IDX_W = (N_CMD > 1) ? $clog2(N_CMD) : 1
) (
  input  logic [15:0]      opc_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [LEN_W-1:0] exp_len_o,
  output logic             var_o
);
  logic [N_CMD-1:0] match;

  genvar g;
  generate
    for (g = 0; g < N_CMD; g++) begin : g_cmp
      assign match[g] = (TBL_OPC[g*16 +: 16] == opc_i);
    end
  endgenerate

  // Lowest matching index wins
  always_comb begin
    hit_o     = 1'b0;
    idx_o     = '0;
    exp_len_o = '0;
    var_o     = 1'b0;
    for (int i = N_CMD - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o     = 1'b1;
        idx_o     = IDX_W'(i);
        exp_len_o = TBL_LEN[i*LEN_W +: LEN_W];
        var_o     = TBL_VAR[i];
      end
    end
  end
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int IDX_W       = 4,
  parameter int PAYLOAD_MAX = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [LEN_W-1:0] exp_len_i,
  input  logic             var_i,
  input  logic             hnd_done_i,
  input  logic [15:0]      hnd_rc_i,
  input  logic [LEN_W-1:0] hnd_olen_i,
  output logic             hnd_req_o,
  output logic [IDX_W-1:0] hnd_idx_o,
  output logic [LEN_W-1:0] hnd_len_o,
  output logic             wr_o,
  output logic             db_clr_o,
  output logic [15:0]      rc_o,
  output logic [LEN_W-1:0] olen_o
);
  localparam logic [LEN_W:0] LIMIT = (LEN_W+1)'(PAYLOAD_MAX);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] ilen_q, ilen_d;
  logic [15:0]      rc_q, rc_d;
  logic [LEN_W-1:0] olen_q, olen_d;
  logic             accept;
  logic             len_ok;
  logic             too_long;

  assign accept   = (state_q == ST_IDLE) && db_i;
  assign len_ok   = var_i || (len_i == exp_len_i);
  assign too_long = {1'b0, hnd_olen_i} > LIMIT;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    ilen_d  = ilen_q;
    rc_d    = rc_q;
    olen_d  = olen_q;
    unique case (state_q)
      ST_IDLE: begin
        if (db_i) begin
          if (!hit_i) begin
            rc_d    = RC_UNSUPPORTED;
            olen_d  = len_i;
            state_d = ST_WRITE;
          end else if (!len_ok) begin
            rc_d    = RC_BAD_LENGTH;
            olen_d  = len_i;
            state_d = ST_WRITE;
          end else begin
            idx_d   = idx_i;
            ilen_d  = len_i;
            state_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (hnd_done_i) begin
          if (too_long) begin
            rc_d   = RC_INTERNAL;
            olen_d = '0;
          end else begin
            rc_d   = hnd_rc_i;
            olen_d = hnd_olen_i;
          end
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: state_d = ST_CLEAR;
      ST_CLEAR: state_d = ST_DRAIN;
      ST_DRAIN: if (!db_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ilen_q  <= '0;
      rc_q    <= '0;
      olen_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        idx_q  <= idx_d;
        ilen_q <= ilen_d;
      end
      if (state_d == ST_WRITE && state_q != ST_WRITE) begin
        rc_q   <= rc_d;
        olen_q <= olen_d;
      end
    end
  end

  assign hnd_req_o = (state_q == ST_RUN);
  assign hnd_idx_o = idx_q;
  assign hnd_len_o = ilen_q;
  assign wr_o      = (state_q == ST_WRITE);
  assign db_clr_o  = (state_q == ST_CLEAR);
  assign rc_o      = rc_q;
  assign olen_o    = olen_q;

  // R2: a missing opcode never starts a handler
  a_r2_no_start_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit_i) |=> !hnd_req_o);

  // R3: a wrong fixed length never starts a handler
  a_r3_no_start_bad_len: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit_i && !var_i && (len_i != exp_len_i)) |=> !hnd_req_o);

  // R1: request held until the handler reports done
  a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (hnd_req_o && !hnd_done_i) |=> hnd_req_o);

  // R11: started index and length stay stable for the whole request
  a_r11_args_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hnd_req_o && $past(hnd_req_o)) |-> ($stable(hnd_idx_o) && $stable(hnd_len_o)));

  // R9: overflowing output length is reported as internal error
  a_r9_overflow_code: assert property (@(posedge clk) disable iff (!rst_n)
    (hnd_req_o && hnd_done_i && too_long) |=> (rc_o == RC_INTERNAL && olen_o == '0));

  // R7: doorbell clear follows the register writes by one cycle
  a_r7_clear_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |=> (db_clr_o && !wr_o));

  // R8: while the doorbell is still high after completion, nothing restarts
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (db_clr_o || (state_q == ST_DRAIN && db_i)) |=> (!hnd_req_o && !wr_o));
endmodule

// File: rtl/mbox_pack.sv
module mbox_pack #(
  parameter int LEN_W  = 16,
  parameter int STS_W  = 64,
  parameter int RC_LSB = 32
) (
  input  logic [15:0]         rc_i,
  input  logic [LEN_W-1:0]    olen_i,
  output logic [16+LEN_W-1:0] cmd_wdata_o,
  output logic [STS_W-1:0]    sts_wdata_o
);
  always_comb begin
    cmd_wdata_o = {olen_i, 16'h0000};
    sts_wdata_o = '0;
    sts_wdata_o[RC_LSB +: 16] = rc_i;
  end
endmodule

// File: rtl/mbox_dispatch.sv
module mbox_dispatch #(
  parameter int LEN_W       = 16,
  parameter int STS_W       = 64,
  parameter int RC_LSB      = 32,
  parameter int PAYLOAD_MAX = 256,
  parameter int N_CMD       = 13,
  parameter logic [N_CMD*16-1:0] TBL_OPC = {
    16'h4103, 16'h4102, 16'h4100, 16'h4000, 16'h0401, 16'h0400, 16'h0301,
    16'h0300, 16'h0200, 16'h0103, 16'h0102, 16'h0101, 16'h0100},
  parameter logic [N_CMD*LEN_W-1:0] TBL_LEN = {
    LEN_W'(0), LEN_W'(8), LEN_W'(0), LEN_W'(0), LEN_W'(24), LEN_W'(0), LEN_W'(8),
    LEN_W'(0), LEN_W'(0), LEN_W'(4), LEN_W'(0), LEN_W'(0), LEN_W'(1)},
  parameter logic [N_CMD-1:0] TBL_VAR = 13'b1_0000_0000_0010,
  localparam int IDX_W = (N_CMD > 1) ? $clog2(N_CMD) : 1,
  localparam int CMD_W = 16 + LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db_i,
  input  logic [CMD_W-1:0] cmd_reg_i,
  output logic             cmd_wr_o,
  output logic [CMD_W-1:0] cmd_wdata_o,
  output logic             sts_wr_o,
  output logic [STS_W-1:0] sts_wdata_o,
  output logic             db_clr_o,
  output logic             hnd_req_o,
  output logic [IDX_W-1:0] hnd_idx_o,
  output logic [LEN_W-1:0] hnd_len_o,
  input  logic             hnd_done_i,
  input  logic [15:0]      hnd_rc_i,
  input  logic [LEN_W-1:0] hnd_olen_i
);
  logic             rst_sync_n;
  logic [15:0]      opc;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] exp_len;
  logic             var_len;
  logic             wr;
  logic [15:0]      rc;
  logic [LEN_W-1:0] olen;

  assign opc = {cmd_reg_i[15:8], cmd_reg_i[7:0]};

  mbox_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mbox_lookup #(
    .LEN_W   (LEN_W),
    .N_CMD   (N_CMD),
    .TBL_OPC (TBL_OPC),
    .TBL_LEN (TBL_LEN),
    .TBL_VAR (TBL_VAR)
  ) u_lookup (
    .opc_i     (opc),
    .hit_o     (hit),
    .idx_o     (idx),
    .exp_len_o (exp_len),
    .var_o     (var_len)
  );

  mbox_seq #(
    .LEN_W       (LEN_W),
    .IDX_W       (IDX_W),
    .PAYLOAD_MAX (PAYLOAD_MAX)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .db_i       (db_i),
    .len_i      (cmd_reg_i[CMD_W-1:16]),
    .hit_i      (hit),
    .idx_i      (idx),
    .exp_len_i  (exp_len),
    .var_i      (var_len),
    .hnd_done_i (hnd_done_i),
    .hnd_rc_i   (hnd_rc_i),
    .hnd_olen_i (hnd_olen_i),
    .hnd_req_o  (hnd_req_o),
    .hnd_idx_o  (hnd_idx_o),
    .hnd_len_o  (hnd_len_o),
    .wr_o       (wr),
    .db_clr_o   (db_clr_o),
    .rc_o       (rc),
    .olen_o     (olen)
  );

  mbox_pack #(
    .LEN_W  (LEN_W),
    .STS_W  (STS_W),
    .RC_LSB (RC_LSB)
  ) u_pack (
    .rc_i        (rc),
    .olen_i      (olen),
    .cmd_wdata_o (cmd_wdata_o),
    .sts_wdata_o (sts_wdata_o)
  );

  assign cmd_wr_o = wr;
  assign sts_wr_o = wr;

  // R5: opcode bytes are cleared in every command register write
  a_r5_opcode_cleared: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_wr_o |-> (cmd_wdata_o[15:0] == 16'h0000));

  // R10: no activity while the synchronised reset is asserted
  a_r10_quiet_in_reset: assert property (@(posedge clk)
    !rst_sync_n |-> !(hnd_req_o || cmd_wr_o || sts_wr_o || db_clr_o));
endmodule

// File: tb/test_mbox_dispatch.sv
module test_mbox_dispatch;
  localparam int LEN_W = 16;
  localparam int CMD_W = 32;
  localparam int STS_W = 64;
  localparam int IDX_W = 4;
  localparam int NC    = 13;
  localparam int PMAX  = 256;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             db;
  logic [CMD_W-1:0] cmd_reg;
  logic [STS_W-1:0] sts_reg;
  logic             cmd_wr, sts_wr, db_clr, hreq, hdone;
  logic [CMD_W-1:0] cmd_wdata;
  logic [STS_W-1:0] sts_wdata;
  logic [IDX_W-1:0] hidx;
  logic [LEN_W-1:0] hlen;
  logic [15:0]      hrc_v;
  logic [LEN_W-1:0] hout_v;
  int               hlat;
  int               hcnt;

  logic             host_wr;
  logic [CMD_W-1:0] host_cmd;

  int pass_n = 0;
  int total_n = 0;

  int cyc = 0, wr_cnt, wr_cyc, clr_cyc, starts;
  logic [IDX_W-1:0] seen_idx;
  logic [LEN_W-1:0] seen_len;
  logic hprev;

  logic [15:0] t_opc [NC] = '{16'h0100, 16'h0101, 16'h0102, 16'h0103, 16'h0200,
    16'h0300, 16'h0301, 16'h0400, 16'h0401, 16'h4000, 16'h4100, 16'h4102, 16'h4103};
  int t_len [NC] = '{1, 0, 0, 4, 0, 0, 8, 0, 24, 0, 0, 8, 0};
  bit t_var [NC] = '{0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1};

  always #10 clk = ~clk;

  mbox_dispatch i_mbox_dispatch (
    .clk         (clk),
    .rst_n       (rst_n),
    .db_i        (db),
    .cmd_reg_i   (cmd_reg),
    .cmd_wr_o    (cmd_wr),
    .cmd_wdata_o (cmd_wdata),
    .sts_wr_o    (sts_wr),
    .sts_wdata_o (sts_wdata),
    .db_clr_o    (db_clr),
    .hnd_req_o   (hreq),
    .hnd_idx_o   (hidx),
    .hnd_len_o   (hlen),
    .hnd_done_i  (hdone),
    .hnd_rc_i    (hrc_v),
    .hnd_olen_i  (hout_v)
  );

  assign hdone = hreq && (hcnt == hlat);

  // register file and handler model
  always @(posedge clk) begin
    if (!rst_n) begin
      db <= 1'b0; cmd_reg <= '0; sts_reg <= '0; hcnt <= 0;
    end else begin
      if (cmd_wr) cmd_reg <= cmd_wdata;
      if (sts_wr) sts_reg <= sts_wdata;
      if (db_clr) db <= 1'b0;
      if (host_wr) begin cmd_reg <= host_cmd; db <= 1'b1; end
      hcnt <= hreq ? hcnt + 1 : 0;
    end
  end

  // monitor
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cmd_wr) begin wr_cnt = wr_cnt + 1; wr_cyc = cyc; end
    if (db_clr) clr_cyc = cyc;
    if (hreq && !hprev) begin starts = starts + 1; seen_idx = hidx; seen_len = hlen; end
    hprev = hreq;
  end

  task automatic chk(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    total_n++;
    if (ok) pass_n++;
    else $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic run_cmd(input logic [7:0] s, input logic [7:0] c, input logic [15:0] len,
                         input int lat, input logic [15:0] rc, input logic [15:0] hout,
                         input bit scribble);
    int ei; bit ehit; bit estart;
    logic [15:0] erc, elen;
    logic [15:0] opc;
    opc = {s, c};
    ehit = 0; ei = 0;
    for (int i = NC - 1; i >= 0; i--) if (t_opc[i] == opc) begin ehit = 1; ei = i; end
    estart = 0;
    if (!ehit) begin erc = 16'h0003; elen = len; end
    else if (!t_var[ei] && int'(len) != t_len[ei]) begin erc = 16'h0016; elen = len; end
    else begin
      estart = 1;
      if (int'(hout) > PMAX) begin erc = 16'h0004; elen = 16'h0; end
      else begin erc = rc; elen = hout; end
    end
    @(negedge clk);
    wr_cnt = 0; wr_cyc = 0; clr_cyc = 0; starts = 0;
    hlat = lat; hrc_v = rc; hout_v = hout;
    host_cmd = {len, s, c}; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    if (scribble) begin
      repeat (2) @(negedge clk);
      host_cmd = {16'h0001, 8'h01, 8'h00}; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
    end
    for (int k = 0; k < 60; k++) begin
      if (!db) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk(ehit ? (estart ? "R5" : "R3") : "R2", cmd_reg == {elen, 16'h0},
        64'(cmd_reg), 64'({elen, 16'h0}));
    chk(estart && int'(hout) > PMAX ? "R9" : "R6", sts_reg == (64'(erc) << 32),
        sts_reg, 64'(erc) << 32);
    chk("R8", starts == int'(estart) && wr_cnt == 1,
        64'(starts * 16 + wr_cnt), 64'(int'(estart) * 16 + 1));
    chk("R7", clr_cyc == wr_cyc + 1, 64'(clr_cyc), 64'(wr_cyc + 1));
    if (estart)
      chk(scribble ? "R11" : (t_var[ei] ? "R4" : "R1"),
          seen_idx == IDX_W'(ei) && seen_len == len,
          {32'(seen_idx), 16'h0, seen_len}, {32'(ei), 16'h0, len});
  endtask

  task automatic run_all();
    host_wr = 1'b0; host_cmd = '0; hlat = 0; hrc_v = '0; hout_v = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: quiet after reset
    chk("R10", !(hreq || cmd_wr || sts_wr || db_clr), 64'({hreq, cmd_wr, sts_wr, db_clr}), 64'h0);
    // R1 R2 R3: sweep command sets 0..0x47, commands 0..7
    for (int s = 0; s < 8'h48; s++) begin
      for (int c = 0; c < 8; c++) begin
        bit hit_b; int ix;
        hit_b = 0; ix = 0;
        for (int i = 0; i < NC; i++) if (t_opc[i] == {8'(s), 8'(c)}) begin hit_b = 1; ix = i; end
        if (hit_b) begin
          logic [15:0] gl;
          gl = t_var[ix] ? 16'd37 : 16'(t_len[ix]);
          run_cmd(8'(s), 8'(c), gl, (s + c) % 3, 16'(s ^ c), 16'(c * 9 + 3), 0);
          if (!t_var[ix]) run_cmd(8'(s), 8'(c), gl + 16'd1, 0, 16'h0, 16'h0, 0);
        end else begin
          run_cmd(8'(s), 8'(c), 16'(s + c), 0, 16'h0, 16'h0, 0);
        end
      end
    end
    run_cmd(8'hFF, 8'h00, 16'h0, 0, 16'h0, 16'h0, 0);   // R2 miss, high set
    run_cmd(8'h81, 8'h03, 16'h8, 0, 16'h0, 16'h0, 0);   // R2 miss
    // R4: variable-length entry at the length extremes
    run_cmd(8'h41, 8'h03, 16'h0000, 1, 16'h0000, 16'h0, 0);
    run_cmd(8'h41, 8'h03, 16'hFFFF, 2, 16'h0000, 16'h0, 0);
    // R9: output length limit, zero-latency handler
    run_cmd(8'h03, 8'h00, 16'h0, 0, 16'h0000, 16'd256, 0);
    run_cmd(8'h03, 8'h00, 16'h0, 0, 16'h0000, 16'd257, 0);
    run_cmd(8'h04, 8'h01, 16'd24, 3, 16'h0000, 16'hFFFF, 0);
    // R11 R8: host rewrites command and doorbell during a slow handler
    run_cmd(8'h41, 8'h02, 16'd8, 8, 16'h0005, 16'd8, 1);
    run_cmd(8'h01, 8'h03, 16'd4, 6, 16'h0000, 16'd0, 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        total_n++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", pass_n, total_n);
    $finish;
  end
endmodule